// File: doc/BRIEF.md
# Indirect Register Port with Interrupt Flags

This block is the host-facing register front end of a serial link controller. The host sees only two locations. One is a pointer port that holds a 3-bit register number. The other is a data port that reads or writes whichever register the pointer currently selects. Six 16-bit registers sit behind the pointer:

- Register 0 is the control/status word. It holds the interrupt flags, the interrupt enable, a stop status bit, the transmit-demand command and the halt/start command strobes.
- Register 4 controls a modem status line.
- Registers 1, 2, 3 and 5 are plain parameter storage.

Internal logic raises the interrupt flags with one-cycle event pulses. The host clears a flag by writing 1 to it. The interrupt output is high while any flag is set and interrupts are enabled. A transmit-demand bit lets the host kick the transmitter; the transmitter clears the bit once it has taken the request. The modem line bit either mirrors an input pin or drives an output pin, depending on a direction bit.

Top module: `csr_port_top`

## Requirements
- R1: A write with `host_port`=0 loads the pointer from `host_wdata[2:0]`. A read with `host_port`=0 returns the pointer in bits 2:0, with the other bits 0. With `host_port`=1, reads and writes go to the register the pointer selects.
- R2: Registers 1, 2, 3 and 5 store and return all 16 written bits, independently of each other.
- R3: Pointer values 6 and 7 read as 0. Writes through them change no register.
- R4: Register 0 bits 11:8 are interrupt flags. A pulse on `evt_set[i]` sets flag i on the next clock. Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R5: If an event pulse and a host clear hit the same flag in the same cycle, the flag ends up set.
- R6: Register 0 bit 15 reads as the OR of the flag bits. Writes to bit 15 have no effect.
- R7: Register 0 bit 6 is a read/write interrupt enable. `irq_o` is high exactly when bit 6 is 1 and at least one flag is set.
- R8: Register 0 bit 3 is transmit demand. Writing 1 sets it, and writing 0 does nothing. A `dmd_ack` pulse clears it, unless a write of 1 arrives in the same cycle. `dmd_pend` shows its value.
- R9: Writing 1 to register 0 bit 2 (halt) does three things on the next clock: it sets stop status (bit 5), clears the enable and clears all flags. Writing 1 to bit 1 (start) clears stop status; if halt and start are both 1, halt wins. Bits 2 and 1 always read 0.
- R10: Register 4 bit 0 is the line direction, and `dsr_oe` follows it. With the direction at 0, bit 1 reads the `dsr_in` pin and written values of bit 1 are dropped. A write that sets bit 0 stores bit 1, and that stored value drives `dsr_out` and reads back.
- R11: After reset the pointer and all registers are 0, and `irq_o`, `dmd_pend`, `dsr_out` and `dsr_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_port | input | 1 | 0 selects the pointer port, 1 the data port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the selected port (combinational) |
| evt_set | input | 4 | Internal event pulses, one per flag |
| dmd_ack | input | 1 | Transmitter has taken the demand |
| dmd_pend | output | 1 | Transmit demand pending |
| irq_o | output | 1 | Interrupt request |
| dsr_in | input | 1 | Modem line input pin |
| dsr_out | output | 1 | Modem line output value |
| dsr_oe | output | 1 | Modem line output enable |

## Verification
The bench goes after the corner cases where flag and command bits interact.

- **Set and clear in the same cycle.** An event and a host clear land on the same flag in one cycle. A design that let the clear win would lose an interrupt.
- **Writing 0 to a flag.** A design that decoded flag writes as plain stores would wipe pending flags.
- **Writing the summary bit.** A design that stored bit 15 would report a summary that no flag backs.
- **Halt.** A halt must drop the interrupt, and a later start must release stop status. A design that missed either would keep interrupting while stopped, or stay stopped for good.
- **Demand acknowledge against a write of 1.** The bench checks that an acknowledge clears transmit demand, and that a simultaneous write of 1 keeps it set.
- **Modem line direction.** The bench writes the line bit in mirror mode to expose a design that latches it. It then drives `dsr_in` low in drive mode, so a design that still mirrors the pin reads back the wrong value.

// File: rtl/csr_port_pkg.sv
package csr_port_pkg;
    localparam int DW       = 16;
    localparam int AW       = 3;
    localparam int NREG     = 6;
    localparam int NFLAG    = 4;
    localparam int FLAG_LSB = 8;
    localparam int SUM_BIT  = 15;
    localparam int EN_BIT   = 6;
    localparam int STOP_BIT = 5;
    localparam int DMD_BIT  = 3;
    localparam int HALT_BIT = 2;
    localparam int GO_BIT   = 1;
    localparam int CTL_IDX  = 0;
    localparam int LINE_IDX = 4;

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          en;
        logic          stop;
        logic          dmd;
    } ctl_t;
endpackage

// File: rtl/csr_flag_bank.sv
module csr_flag_bank
    import csr_port_pkg::*;
#(
    parameter int N = NFLAG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         wipe_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (wipe_i) flag_d = '0;
        flag_d = (flag_d & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0 && !wipe_i) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/csr_line_ctl.sv
module csr_line_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic dir_wr_i,
    input  logic val_wr_i,
    input  logic pin_i,
    output logic dir_o,
    output logic rd_val_o,
    output logic pin_o
);
    typedef struct packed {
        logic dir;
        logic val;
    } line_t;

    line_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            s_d.dir = dir_wr_i;
            if (dir_wr_i) s_d.val = val_wr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dir_o    = s_q.dir;
    assign pin_o    = s_q.val;
    assign rd_val_o = s_q.dir ? s_q.val : pin_i;

    // R10
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i) |=> $stable(pin_o));
endmodule

// File: rtl/csr_port_top.sv
module csr_port_top
    import csr_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_port,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    input  logic [NFLAG-1:0] evt_set,
    input  logic             dmd_ack,
    output logic             dmd_pend,
    output logic             irq_o,
    input  logic             dsr_in,
    output logic             dsr_out,
    output logic             dsr_oe
);
    localparam int NPLAIN = NREG;

    ctl_t ctl_d, ctl_q;
    logic [DW-1:0] plain_d [NPLAIN];
    logic [DW-1:0] plain_q [NPLAIN];

    logic             wr_ptr, wr_dat, wr_ctl, wr_line, halt;
    logic [NFLAG-1:0] flags, flag_clr;
    logic             line_dir, line_rd;
    logic [DW-1:0]    ctl_word;

    assign wr_ptr  = host_wr && !host_port;
    assign wr_dat  = host_wr && host_port;
    assign wr_ctl  = wr_dat && (int'(ctl_q.ptr) == CTL_IDX);
    assign wr_line = wr_dat && (int'(ctl_q.ptr) == LINE_IDX);
    assign halt    = wr_ctl && host_wdata[HALT_BIT];
    assign flag_clr = wr_ctl ? host_wdata[FLAG_LSB +: NFLAG] : '0;

    csr_flag_bank #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(evt_set), .clr_i(flag_clr),
        .wipe_i(halt), .flag_o(flags)
    );

    csr_line_ctl u_line (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_line), .dir_wr_i(host_wdata[0]),
        .val_wr_i(host_wdata[1]), .pin_i(dsr_in), .dir_o(line_dir),
        .rd_val_o(line_rd), .pin_o(dsr_out)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ptr) ctl_d.ptr = host_wdata[AW-1:0];
        if (wr_ctl) begin
            ctl_d.en = host_wdata[EN_BIT];
            if (host_wdata[DMD_BIT]) ctl_d.dmd = 1'b1;
            else if (dmd_ack)        ctl_d.dmd = 1'b0;
            if (host_wdata[GO_BIT])  ctl_d.stop = 1'b0;
        end else if (dmd_ack) begin
            ctl_d.dmd = 1'b0;
        end
        if (halt) begin
            ctl_d.stop = 1'b1;
            ctl_d.en   = 1'b0;
        end
    end

    generate
        for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
            if (g == CTL_IDX || g == LINE_IDX) begin : g_none
                assign plain_d[g] = '0;
            end else begin : g_store
                assign plain_d[g] = (wr_dat && int'(ctl_q.ptr) == g)
                                    ? host_wdata : plain_q[g];
            end
            always_ff @(posedge clk) begin
                if (!rst_n) plain_q[g] <= '0;
                else        plain_q[g] <= plain_d[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        ctl_word = '0;
        ctl_word[SUM_BIT] = |flags;
        ctl_word[FLAG_LSB +: NFLAG] = flags;
        ctl_word[EN_BIT]   = ctl_q.en;
        ctl_word[STOP_BIT] = ctl_q.stop;
        ctl_word[DMD_BIT]  = ctl_q.dmd;
    end

    always_comb begin
        host_rdata = '0;
        if (!host_port) begin
            host_rdata[AW-1:0] = ctl_q.ptr;
        end else if (int'(ctl_q.ptr) == CTL_IDX) begin
            host_rdata = ctl_word;
        end else if (int'(ctl_q.ptr) == LINE_IDX) begin
            host_rdata[0] = line_dir;
            host_rdata[1] = line_rd;
        end else if (int'(ctl_q.ptr) < NREG) begin
            host_rdata = plain_q[ctl_q.ptr];
        end
    end

    assign irq_o    = ctl_q.en && (|flags);
    assign dmd_pend = ctl_q.dmd;
    assign dsr_oe   = line_dir;

    // R8
    dmd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmd_ack && !(wr_ctl && host_wdata[DMD_BIT])) |=> !dmd_pend);

    // R8
    dmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && host_wdata[DMD_BIT]) |=> dmd_pend);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!irq_o && ctl_q.stop));

    // R1
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr |=> (ctl_q.ptr == $past(host_wdata[AW-1:0])));
endmodule

// File: tb/sim_csr_port_top.sv
module sim_csr_port_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_port = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [3:0]  evt_set = '0;
    logic        dmd_ack = 1'b0;
    logic        dmd_pend, irq_o, dsr_out, dsr_oe;
    logic        dsr_in = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    csr_port_top u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_port(host_port),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_set(evt_set),
        .dmd_ack(dmd_ack), .dmd_pend(dmd_pend), .irq_o(irq_o),
        .dsr_in(dsr_in), .dsr_out(dsr_out), .dsr_oe(dsr_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic port, input logic [15:0] d);
        @(negedge clk);
        host_port = port; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic sel(input int r);
        put(1'b0, 16'(r));
    endtask

    task automatic get(output logic [15:0] d);
        host_port = 1'b1; #1;
        d = host_rdata;
    endtask

    task automatic pulse(input logic [3:0] e);
        @(negedge clk); evt_set = e;
        @(negedge clk); evt_set = '0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        host_port = 1'b0; #1;
        check("R11 ptr", host_rdata, 16'h0);
        get(v); check("R11 ctl", v, 16'h0);
        check("R11 outs", {12'h0, irq_o, dmd_pend, dsr_out, dsr_oe}, 16'h0);
    endtask

    task automatic t_pointer;
        sel(5);
        host_port = 1'b0; #1;
        check("R1 ptr readback", host_rdata, 16'h0005);
        put(1'b0, 16'hFFFB);
        host_port = 1'b0; #1;
        check("R1 ptr width", host_rdata, 16'h0003);
    endtask

    task automatic t_plain;
        logic [15:0] v;
        sel(1); put(1'b1, 16'hA5C3);
        sel(2); put(1'b1, 16'h1234);
        sel(3); put(1'b1, 16'hFFFF);
        sel(5); put(1'b1, 16'h8001);
        sel(1); get(v); check("R2 reg1", v, 16'hA5C3);
        sel(2); get(v); check("R2 reg2", v, 16'h1234);
        sel(3); get(v); check("R2 reg3", v, 16'hFFFF);
        sel(5); get(v); check("R2 reg5", v, 16'h8001);
        check("R1 data port read", v, 16'h8001);
    endtask

    task automatic t_unimpl;
        logic [15:0] v;
        sel(6); put(1'b1, 16'h5555); get(v); check("R3 reg6", v, 16'h0);
        sel(7); put(1'b1, 16'hFFFF); get(v); check("R3 reg7", v, 16'h0);
        sel(1); get(v); check("R3 reg1 intact", v, 16'hA5C3);
        sel(0); get(v); check("R3 ctl intact", v, 16'h0);
    endtask

    task automatic t_flags;
        logic [15:0] v;
        sel(0);
        pulse(4'b0101);
        get(v); check("R4 set", v, 16'h8500);
        check("R7 irq off when disabled", {15'h0, irq_o}, 16'h0);
        put(1'b1, 16'h0000);
        get(v); check("R4 write0 no effect", v, 16'h8500);
        put(1'b1, 16'h0100);
        get(v); check("R4 w1c", v, 16'h8400);
        put(1'b1, 16'h8000);
        get(v); check("R6 summary not writable", v, 16'h8400);
        put(1'b1, 16'h0400);
        get(v); check("R6 summary clear", v, 16'h0000);
    endtask

    task automatic t_collide;
        logic [15:0] v;
        sel(0);
        pulse(4'b0010);
        @(negedge clk);
        host_port = 1'b1; host_wdata = 16'h0200; host_wr = 1'b1; evt_set = 4'b0010;
        @(negedge clk);
        host_wr = 1'b0; evt_set = '0;
        get(v); check("R5 set wins", v, 16'h8200);
        put(1'b1, 16'h0200);
        get(v); check("R5 then clears", v, 16'h0000);
    endtask

    task automatic t_irq;
        sel(0);
        put(1'b1, 16'h0040);
        check("R7 en no flag", {15'h0, irq_o}, 16'h0);
        pulse(4'b1000);
        #1; check("R7 irq high", {15'h0, irq_o}, 16'h1);
        put(1'b1, 16'h0000);
        check("R7 disable drops irq", {15'h0, irq_o}, 16'h0);
        put(1'b1, 16'h0040);
        check("R7 re-enable", {15'h0, irq_o}, 16'h1);
    endtask

    task automatic t_halt;
        logic [15:0] v;
        sel(0);
        put(1'b1, 16'h0044);
        get(v); check("R9 halt state", v, 16'h0020);
        check("R9 irq off", {15'h0, irq_o}, 16'h0);
        put(1'b1, 16'h0006);
        get(v); check("R9 halt beats start", v, 16'h0020);
        put(1'b1, 16'h0002);
        get(v); check("R9 start clears stop", v, 16'h0000);
    endtask

    task automatic t_demand;
        logic [15:0] v;
        sel(0);
        put(1'b1, 16'h0008);
        get(v); check("R8 set", v, 16'h0008);
        check("R8 pend", {15'h0, dmd_pend}, 16'h1);
        put(1'b1, 16'h0000);
        get(v); check("R8 write0 keeps", v, 16'h0008);
        @(negedge clk); dmd_ack = 1'b1;
        host_port = 1'b1; host_wdata = 16'h0008; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0; dmd_ack = 1'b0;
        check("R8 write beats ack", {15'h0, dmd_pend}, 16'h1);
        @(negedge clk); dmd_ack = 1'b1;
        @(negedge clk); dmd_ack = 1'b0;
        check("R8 ack clears", {15'h0, dmd_pend}, 16'h0);
    endtask

    task automatic t_line;
        logic [15:0] v;
        sel(4);
        dsr_in = 1'b1; get(v); check("R10 mirror 1", v, 16'h0002);
        dsr_in = 1'b0; get(v); check("R10 mirror 0", v, 16'h0000);
        put(1'b1, 16'h0002);
        get(v); check("R10 ignored write", v, 16'h0000);
        check("R10 no drive", {14'h0, dsr_oe, dsr_out}, 16'h0);
        put(1'b1, 16'h0003);
        get(v); check("R10 rw read", v, 16'h0003);
        check("R10 drive", {14'h0, dsr_oe, dsr_out}, 16'h3);
        put(1'b1, 16'h0001);
        dsr_in = 1'b1;
        get(v); check("R10 rw low", v, 16'h0001);
        check("R10 drive low", {14'h0, dsr_oe, dsr_out}, 16'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_plain();
        t_unimpl();
        t_flags();
        t_collide();
        t_irq();
        t_halt();
        t_demand();
        t_line();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule